// File: doc/BRIEF.md
# Root Port Interrupt Status and Mask Unit

This block gathers the 32 interrupt sources of one root port into one interrupt line. Sources 0 to 3 are the four legacy INTx wires and are level-sensitive: their status bits follow the wire levels. Every other source is rising-edge-sensitive: a rising edge sets a sticky status bit, which stays set until software writes a one to that bit. Link-up (12), link-down (14), bandwidth management (11), the port error and error-report group (4 to 7), completion abort (21), completion timeout (23), requester-ID map error (22), MSI error (18) and MSI bad data (19) each have a fixed position in this vector.

Software uses a four-address register port. It can read the status and the mask, clear edge status bits by writing ones, and change the mask only through a set strobe and a clear strobe. Status bits record events even while they are masked. The registered output `irq_o` is high whenever a set status bit is unmasked.

Top module: `port_irq_unit`

## Requirements
- R1: After reset every status bit reads 0, every mask bit reads 1 and `irq_o` is 0.
- R2: Status bits 0 to 3 show the level of `src_i[3:0]` one clock after it is sampled, and drop when the source drops.
- R3: For bits 4 to 31, a 0-to-1 change on `src_i` sets the status bit at the next clock edge. The bit stays set after the source falls, and a source that is held high does not set it again once it has been cleared.
- R4: A write to address 0 (status) clears each edge status bit whose data bit is 1. Bits whose data bit is 0 are unchanged, and bits 0 to 3 are unaffected.
- R5: When a rising edge and a status clear hit the same bit in the same cycle, the bit ends up set.
- R6: A write to address 2 (mask set) sets each mask bit whose data bit is 1 and leaves the other mask bits unchanged.
- R7: A write to address 3 (mask clear) clears each mask bit whose data bit is 1 and leaves the other mask bits unchanged.
- R8: Reads of address 0 return the status. Reads of addresses 1, 2 and 3 return the mask. A write to address 1 has no effect.
- R9: `irq_o` is 1 exactly when some status bit is 1 and its mask bit is 0, as seen in the same cycle. A pending masked source therefore raises `irq_o` at the clock edge that takes the unmask write.
- R10: A masked source still sets its status bit.
- R11: Writing all ones to mask set and then all ones to status, with no source active, leaves every status bit 0, every mask bit 1 and `irq_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Interrupt sources; bits 3:0 are level-type, the rest are edge-type |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 status, 1 mask, 2 mask set, 3 mask clear |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Two events can land on the same status bit in one cycle: a new rising edge from a source, and a software write that clears that bit. The bench provokes this by raising bit 21 while it writes a clear mask that covers bits 21 and 23. It expects bit 21 to stay set and bit 23 to clear. A second write then clears bit 21 while its source is still held high, and the bench expects the bit to stay clear, which shows that only edges set these bits.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_MASK   = 2'd1,
    SEL_MSET   = 2'd2,
    SEL_MCLR   = 2'd3
  } reg_sel_e;

  localparam int unsigned SRC_PORT_ERR    = 4;
  localparam int unsigned SRC_BW_MGMT     = 11;
  localparam int unsigned SRC_LINK_UP     = 12;
  localparam int unsigned SRC_LINK_DOWN   = 14;
  localparam int unsigned SRC_MSI_ERR     = 18;
  localparam int unsigned SRC_MSI_BADDATA = 19;
  localparam int unsigned SRC_CPL_ABORT   = 21;
  localparam int unsigned SRC_RID_MAPERR  = 22;
  localparam int unsigned SRC_CPL_TIMEOUT = 23;
endpackage

// File: rtl/pirq_capture.sv
module pirq_capture #(
  parameter int unsigned NUM_SRC   = 32,
  parameter int unsigned NUM_LEVEL = 4,
  localparam int unsigned EDGE_W   = NUM_SRC - NUM_LEVEL
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [EDGE_W-1:0]  clr_i,
  output logic [NUM_SRC-1:0] status_o,
  output logic [NUM_SRC-1:0] status_d_o
);
  logic [NUM_SRC-1:0] status_q, status_d;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    if (i < NUM_LEVEL) begin : g_level
      assign status_d[i] = src_i[i];
    end else begin : g_edge
      logic prev_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= 1'b0;
        else         prev_q <= src_i[i];
      end
      // new edge wins over a same-cycle clear
      assign status_d[i] = (src_i[i] & ~prev_q) | (status_q[i] & ~clr_i[i-NUM_LEVEL]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= status_d;
  end

  assign status_o   = status_q;
  assign status_d_o = status_d;
endmodule

// File: rtl/pirq_mask.sv
module pirq_mask #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] mask_o,
  output logic [NUM_SRC-1:0] mask_d_o
);
  logic [NUM_SRC-1:0] mask_q, mask_d;

  assign mask_d = (mask_q | set_i) & ~clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '1;
    else         mask_q <= mask_d;
  end

  assign mask_o   = mask_q;
  assign mask_d_o = mask_d;
endmodule

// File: rtl/pirq_out.sv
module pirq_out #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] status_d_i,
  input  logic [NUM_SRC-1:0] mask_d_i,
  output logic               irq_o
);
  logic irq_q;

  // built from next-state values so irq_o lines up with the registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(status_d_i & ~mask_d_i);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/port_irq_unit.sv
module port_irq_unit
  import pirq_pkg::*;
#(
  parameter int unsigned NUM_SRC   = 32,
  parameter int unsigned NUM_LEVEL = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               reg_we_i,
  input  logic [1:0]         reg_addr_i,
  input  logic [NUM_SRC-1:0] reg_wdata_i,
  output logic [NUM_SRC-1:0] reg_rdata_o,
  output logic               irq_o
);
  localparam int unsigned EDGE_W = NUM_SRC - NUM_LEVEL;

  logic               wr_stat, wr_mset, wr_mclr;
  logic [EDGE_W-1:0]  stat_clr;
  logic [NUM_SRC-1:0] mset, mclr;
  logic [NUM_SRC-1:0] status_q, status_d, mask_q, mask_d;

  assign wr_stat = reg_we_i && (reg_addr_i == SEL_STATUS);
  assign wr_mset = reg_we_i && (reg_addr_i == SEL_MSET);
  assign wr_mclr = reg_we_i && (reg_addr_i == SEL_MCLR);

  assign stat_clr = wr_stat ? reg_wdata_i[NUM_SRC-1:NUM_LEVEL] : '0;
  assign mset     = wr_mset ? reg_wdata_i : '0;
  assign mclr     = wr_mclr ? reg_wdata_i : '0;

  pirq_capture #(.NUM_SRC(NUM_SRC), .NUM_LEVEL(NUM_LEVEL)) u_capture (
    .clk_i, .rst_ni, .src_i,
    .clr_i(stat_clr), .status_o(status_q), .status_d_o(status_d)
  );

  pirq_mask #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk_i, .rst_ni,
    .set_i(mset), .clr_i(mclr), .mask_o(mask_q), .mask_d_o(mask_d)
  );

  pirq_out #(.NUM_SRC(NUM_SRC)) u_out (
    .clk_i, .rst_ni,
    .status_d_i(status_d), .mask_d_i(mask_d), .irq_o
  );

  assign reg_rdata_o = (reg_addr_i == SEL_STATUS) ? status_q : mask_q;
endmodule

// File: rtl/pirq_checker.sv
module pirq_checker #(
  parameter int unsigned NUM_SRC   = 32,
  parameter int unsigned NUM_LEVEL = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] src_i,
  input logic               reg_we_i,
  input logic [1:0]         reg_addr_i,
  input logic [NUM_SRC-1:0] reg_wdata_i,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] status_q,
  input logic [NUM_SRC-1:0] mask_q
);
  localparam logic [NUM_SRC-1:0] EDGE_MASK = ~((NUM_SRC)'((1 << NUM_LEVEL) - 1));

  logic               live_q;
  logic [NUM_SRC-1:0] src_prev_q, rise_c, clr_c, keep_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q     <= 1'b0;
      src_prev_q <= '0;
    end else begin
      live_q     <= 1'b1;
      src_prev_q <= src_i;
    end
  end

  assign rise_c = src_i & ~src_prev_q & EDGE_MASK;
  assign clr_c  = (reg_we_i && reg_addr_i == 2'd0) ? (reg_wdata_i & EDGE_MASK) : '0;
  assign keep_c = status_q & EDGE_MASK & ~clr_c;

  assert_level_mirror_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q |-> (status_q[NUM_LEVEL-1:0] == $past(src_i[NUM_LEVEL-1:0])));

  assert_edge_wins_R3_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q |=> ((status_q & $past(rise_c)) == $past(rise_c)));

  assert_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q |=> ((status_q & $past(keep_c)) == $past(keep_c)));

  assert_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q |=> ((status_q & $past(clr_c & ~rise_c)) == '0));

  assert_mask_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 2'd2) |=> ((mask_q & $past(reg_wdata_i)) == $past(reg_wdata_i)));

  assert_mask_clr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 2'd3) |=> ((mask_q & $past(reg_wdata_i)) == '0));

  assert_mask_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_i && reg_addr_i[1]) |=> $stable(mask_q));

  assert_irq_match_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == |(status_q & ~mask_q));
endmodule

bind port_irq_unit pirq_checker #(.NUM_SRC(NUM_SRC), .NUM_LEVEL(NUM_LEVEL)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i), .reg_we_i(reg_we_i),
  .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .irq_o(irq_o),
  .status_q(status_q), .mask_q(mask_q)
);

// File: tb/sim_port_irq_unit.sv
`timescale 1ns/1ps
module sim_port_irq_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] src_i = '0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = 2'd0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  bit          done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  port_irq_unit u0 (.*);

  typedef struct packed {
    logic [31:0] src;
    logic        we;
    logic [1:0]  addr;
    logic [31:0] wdata;
    logic [31:0] st;
    logic [31:0] mk;
    logic        irq;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VEC [NVEC] = '{
    '{32'h0000_1001, 1'b0, 2'd0, 32'h0,         32'h0000_1001, 32'hFFFF_FFFF, 1'b0}, // R2 R3 R10
    '{32'h0000_0001, 1'b0, 2'd0, 32'h0,         32'h0000_1001, 32'hFFFF_FFFF, 1'b0}, // R3 sticky
    '{32'h0000_0001, 1'b1, 2'd3, 32'h0000_1000, 32'h0000_1001, 32'hFFFF_EFFF, 1'b1}, // R7 R9
    '{32'h0000_0001, 1'b1, 2'd0, 32'hFFFF_FFFF, 32'h0000_0001, 32'hFFFF_EFFF, 1'b0}, // R4
    '{32'h0000_0001, 1'b1, 2'd3, 32'h0000_0001, 32'h0000_0001, 32'hFFFF_EFFE, 1'b1}, // R7 R9
    '{32'h0000_0000, 1'b1, 2'd2, 32'h0000_0000, 32'h0000_0000, 32'hFFFF_EFFE, 1'b0}, // R2 R6
    '{32'h0080_4000, 1'b1, 2'd1, 32'h0000_0000, 32'h0080_4000, 32'hFFFF_EFFE, 1'b0}, // R8 R10
    '{32'h0080_4000, 1'b1, 2'd3, 32'h0000_4000, 32'h0080_4000, 32'hFFFF_AFFE, 1'b1}, // R7 R9
    '{32'h0000_0000, 1'b1, 2'd2, 32'h0000_4000, 32'h0080_4000, 32'hFFFF_EFFE, 1'b0}  // R6
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // drive at negedge, clock once, then read back status, mask and irq
  task automatic step(input logic [31:0] s, input logic we, input logic [1:0] a,
                      input logic [31:0] d, output logic [31:0] st,
                      output logic [31:0] mk, output logic irq);
    @(negedge clk_i);
    src_i = s; reg_we_i = we; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk_i);
    #1;
    reg_we_i = 1'b0;
    reg_addr_i = 2'd0;
    #0.4 st = reg_rdata_o;
    reg_addr_i = 2'd1;
    #0.4 mk = reg_rdata_o;
    irq = irq_o;
  endtask

  initial begin
    logic [31:0] st, mk;
    logic        irq;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    #0.5;
    reg_addr_i = 2'd0;
    #0.4 chk("R1 status", reg_rdata_o, 32'h0);
    reg_addr_i = 2'd1;
    #0.4 chk("R1 mask", reg_rdata_o, 32'hFFFF_FFFF);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i].src, VEC[i].we, VEC[i].addr, VEC[i].wdata, st, mk, irq);
      chk($sformatf("vec%0d status R2-R4/R10", i), st, VEC[i].st);
      chk($sformatf("vec%0d mask R6/R7/R8", i), mk, VEC[i].mk);
      chk($sformatf("vec%0d irq R9", i), {31'b0, irq}, {31'b0, VEC[i].irq});
    end

    // R5: rising edge on 21 while clearing 21 and 23
    step(32'h0020_0000, 1'b1, 2'd0, 32'h00A0_0000, st, mk, irq);
    chk("R5 edge beats clear", st, 32'h0020_4000);
    // R3: held-high source does not recapture after clear
    step(32'h0020_0000, 1'b1, 2'd0, 32'h0020_0000, st, mk, irq);
    chk("R3 no recapture while held", st, 32'h0000_4000);
    // R8: set/clear addresses read back the mask
    #0.5 reg_addr_i = 2'd2;
    #0.4 chk("R8 read addr2", reg_rdata_o, 32'hFFFF_EFFE);
    reg_addr_i = 2'd3;
    #0.4 chk("R8 read addr3", reg_rdata_o, 32'hFFFF_EFFE);
    // R11: mask all then clear all
    step(32'h0, 1'b1, 2'd2, 32'hFFFF_FFFF, st, mk, irq);
    chk("R11 mask all", mk, 32'hFFFF_FFFF);
    step(32'h0, 1'b1, 2'd0, 32'hFFFF_FFFF, st, mk, irq);
    chk("R11 status cleared", st, 32'h0);
    chk("R11 mask kept", mk, 32'hFFFF_FFFF);
    chk("R11 irq low", {31'b0, irq}, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule